// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the front end of a legacy configuration space. A host reaches it through two byte-wide I/O addresses. The even address, set by a parameter, is the index port. The address just above it is the data port. Configuration access stays closed until the host writes a two-byte unlock key to the index port. After that, a byte written to the index port picks a register, and data-port reads and writes reach that register. A lock byte written to the index port closes access again.

A small set of global registers sits below index 0x30. These are a logical-device selector, the identification bytes and four pin-function select bytes that software can read and write back bit by bit. Indices from 0x30 up are banked. An access to one of them goes out on a simple combinational read/write bus, together with the number of the selected logical device, so that the device owning that number can serve it. The logical devices themselves, host-bus arbitration and host address decoding are not part of this block.

Top module: `cfg_keyed_port`

## Requirements
- R1: After reset the port is locked, the index register holds 0x00 and the logical-device selector holds 0x00.
- R2: Access opens only after 0x87 is written to the index port on two index-port writes in a row. Data-port accesses between those two writes do not break the sequence.
- R3: While the port is locked, an index-port write of any byte other than 0x87 clears a pending first key byte, so the next 0x87 counts as the first key byte again.
- R4: While the port is open, an index-port write of 0xAA locks the port and leaves the index register unchanged.
- R5: While the port is locked, reads of either port return 0xFF. Data-port writes then change no register and raise no bank strobe.
- R6: While the port is open, an index-port write of any byte other than 0xAA loads the index register, and an index-port read returns its value.
- R7: Indices 0x20 and 0x21 return the device ID high byte and low byte. Index 0x22 returns the revision byte. Indices 0x23 and 0x24 return the manufacturer ID high byte (0x19) and low byte (0x34). Writes to these indices are ignored.
- R8: Index 0x07 is the logical-device selector. It can be read and written, and its value is driven on bank_sel.
- R9: Indices 0x27, 0x29, 0x2A and 0x2B are independent read/write byte registers, so that a read-modify-write of one bit leaves the other bits unchanged.
- R10: For an index of 0x30 or above, a data-port write raises bank_we for that cycle with bank_idx equal to the index and bank_wdata equal to the byte. A data-port read raises bank_re and returns bank_rdata.
- R11: Any other index below 0x30 reads as 0x00, and writes to it are ignored.
- R12: Reads and writes at addresses other than the two ports change no state, and reads there return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, valid in the cycle of io_rd |
| bank_sel | output | 8 | Selected logical device number |
| bank_idx | output | 8 | Banked register index |
| bank_we | output | 1 | Banked register write strobe |
| bank_re | output | 1 | Banked register read strobe |
| bank_wdata | output | 8 | Banked register write byte |
| bank_rdata | input | 8 | Banked register read byte from the selected device |

## Verification
The bench builds the block with its base address moved to the alternate location 0x4E. The default 0x2E is therefore treated as an ordinary foreign address, and traffic to it must not open, close or alter anything. The device ID is set to 0x0A52 and the revision byte to 0x13, so every identification byte differs from the others and a swapped byte order shows up on a read. The pin-select reset values are set to distinct non-zero bytes, so a write that lands on the wrong one of the four registers becomes visible. Random runs mix stray index bytes between key writes, which exercises back-to-back key detection and lock timing in many orders.

// File: rtl/cfgkp_pkg.sv
package cfgkp_pkg;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_ARMED  = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   localparam logic [7:0] KEY_OPEN  = 8'h87;
   localparam logic [7:0] KEY_CLOSE = 8'hAA;

   localparam logic [7:0] IX_LDN      = 8'h07;
   localparam logic [7:0] IX_DEVID_HI = 8'h20;
   localparam logic [7:0] IX_DEVID_LO = 8'h21;
   localparam logic [7:0] IX_REV      = 8'h22;
   localparam logic [7:0] IX_MFR_HI   = 8'h23;
   localparam logic [7:0] IX_MFR_LO   = 8'h24;
   localparam logic [7:0] IX_BANK_LO  = 8'h30;

   localparam int unsigned NUM_PINSEL = 4;
   localparam logic [NUM_PINSEL*8-1:0] PINSEL_IX = {8'h2B, 8'h2A, 8'h29, 8'h27};

   localparam logic [7:0] RD_FLOAT = 8'hFF;
   localparam logic [7:0] RD_EMPTY = 8'h00;

endpackage

// File: rtl/cfgkp_key.sv
module cfgkp_key
   import cfgkp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       unlocked,
   output logic [7:0] idx
);

   key_state_e state_q, state_d;
   logic [7:0] idx_d;

   always_comb begin
      state_d = state_q;
      idx_d   = idx;
      if (idx_wr) begin
         unique case (state_q)
            KS_LOCKED: state_d = (wdata == KEY_OPEN) ? KS_ARMED : KS_LOCKED;
            KS_ARMED:  state_d = (wdata == KEY_OPEN) ? KS_OPEN  : KS_LOCKED;
            KS_OPEN: begin
               if (wdata == KEY_CLOSE) state_d = KS_LOCKED;
               else                    idx_d   = wdata;
            end
            default:   state_d = KS_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KS_LOCKED;
         idx     <= 8'h00;
      end else begin
         state_q <= state_d;
         idx     <= idx_d;
      end
   end

   assign unlocked = (state_q == KS_OPEN);

   // R2: opening is always caused by a key byte on the index port
   p_open_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(idx_wr && wdata == KEY_OPEN));

   // R4: the lock byte closes the port on the next cycle
   p_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && idx_wr && wdata == KEY_CLOSE) |=> !unlocked);

   // R6: the index only moves on an index-port write
   p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_wr |=> $stable(idx));

endmodule

// File: rtl/cfgkp_globals.sv
module cfgkp_globals
   import cfgkp_pkg::*;
#(
   parameter logic [15:0]              DEV_ID     = 16'h0A52,
   parameter logic [7:0]               DEV_REV    = 8'h13,
   parameter logic [15:0]              MFR_ID     = 16'h1934,
   parameter logic [NUM_PINSEL*8-1:0]  PINSEL_RST = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       unlocked,
   input  logic       wr,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   output logic [7:0] ldn,
   output logic       hit,
   output logic [7:0] rdata
);

   logic [7:0] pin_q [NUM_PINSEL];
   logic [NUM_PINSEL-1:0] pin_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ldn <= 8'h00;
      else if (wr && idx == IX_LDN)  ldn <= wdata;
   end

   for (genvar gi = 0; gi < NUM_PINSEL; gi++) begin : g_pinsel
      localparam logic [7:0] MY_IX = PINSEL_IX[gi*8 +: 8];
      assign pin_hit[gi] = (idx == MY_IX);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               pin_q[gi] <= PINSEL_RST[gi*8 +: 8];
         else if (wr && pin_hit[gi]) pin_q[gi] <= wdata;
      end
   end

   always_comb begin
      hit   = 1'b1;
      rdata = RD_EMPTY;
      unique case (idx)
         IX_LDN:      rdata = ldn;
         IX_DEVID_HI: rdata = DEV_ID[15:8];
         IX_DEVID_LO: rdata = DEV_ID[7:0];
         IX_REV:      rdata = DEV_REV;
         IX_MFR_HI:   rdata = MFR_ID[15:8];
         IX_MFR_LO:   rdata = MFR_ID[7:0];
         default:     hit   = 1'b0;
      endcase
      for (int i = 0; i < NUM_PINSEL; i++) begin
         if (pin_hit[i]) begin
            hit   = 1'b1;
            rdata = pin_q[i];
         end
      end
   end

   // R5: a locked port never changes the device selector
   p_ldn_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(ldn));

   // R8: the selector only moves on a data write at its own index
   p_ldn_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && idx == IX_LDN) |=> $stable(ldn));

endmodule

// File: rtl/cfgkp_bank.sv
module cfgkp_bank
   import cfgkp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       unlocked,
   input  logic       dat_wr,
   input  logic       dat_rd,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   input  logic [7:0] ldn,
   output logic       in_bank,
   output logic [7:0] bank_sel,
   output logic [7:0] bank_idx,
   output logic       bank_we,
   output logic       bank_re,
   output logic [7:0] bank_wdata
);

   assign in_bank    = (idx >= IX_BANK_LO);
   assign bank_sel   = ldn;
   assign bank_idx   = idx;
   assign bank_wdata = wdata;
   assign bank_we    = unlocked & dat_wr & in_bank;
   assign bank_re    = unlocked & dat_rd & in_bank;

   // R5: no bank traffic while the port is locked
   p_bank_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> !bank_we && !bank_re);

   // R10: a bank strobe always addresses the banked range
   p_bank_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_we || bank_re) |-> bank_idx >= IX_BANK_LO);

   // R10: read and write strobes never coincide with the wrong host request
   p_bank_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |-> dat_wr);

endmodule

// File: rtl/cfg_keyed_port.sv
module cfg_keyed_port
   import cfgkp_pkg::*;
#(
   parameter int unsigned              ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]        BASE_ADDR  = 'h2E,
   parameter logic [15:0]              DEV_ID     = 16'h0A52,
   parameter logic [7:0]               DEV_REV    = 8'h13,
   parameter logic [15:0]              MFR_ID     = 16'h1934,
   parameter logic [NUM_PINSEL*8-1:0]  PINSEL_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic [7:0]        bank_sel,
   output logic [7:0]        bank_idx,
   output logic              bank_we,
   output logic              bank_re,
   output logic [7:0]        bank_wdata,
   input  logic [7:0]        bank_rdata
);

   localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

   if (ADDR_W < 2) begin : g_bad_width
      $error("cfg_keyed_port: ADDR_W must be at least 2");
   end
   if (BASE_ADDR[0] != 1'b0) begin : g_bad_base
      $error("cfg_keyed_port: BASE_ADDR must be even");
   end

   logic       hit_idx, hit_dat;
   logic       unlocked, in_bank, glb_hit;
   logic [7:0] idx, ldn, glb_rdata;
   logic       dat_wr_open;

   assign hit_idx     = (io_addr == BASE_ADDR);
   assign hit_dat     = (io_addr == DATA_ADDR);
   assign dat_wr_open = io_wr & hit_dat & unlocked;

   cfgkp_key u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (io_wr & hit_idx),
      .wdata    (io_wdata),
      .unlocked (unlocked),
      .idx      (idx)
   );

   cfgkp_globals #(
      .DEV_ID     (DEV_ID),
      .DEV_REV    (DEV_REV),
      .MFR_ID     (MFR_ID),
      .PINSEL_RST (PINSEL_RST)
   ) u_glb (
      .clk      (clk),
      .rst_n    (rst_n),
      .unlocked (unlocked),
      .wr       (dat_wr_open & ~in_bank),
      .idx      (idx),
      .wdata    (io_wdata),
      .ldn      (ldn),
      .hit      (glb_hit),
      .rdata    (glb_rdata)
   );

   cfgkp_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .unlocked   (unlocked),
      .dat_wr     (io_wr & hit_dat),
      .dat_rd     (io_rd & hit_dat),
      .idx        (idx),
      .wdata      (io_wdata),
      .ldn        (ldn),
      .in_bank    (in_bank),
      .bank_sel   (bank_sel),
      .bank_idx   (bank_idx),
      .bank_we    (bank_we),
      .bank_re    (bank_re),
      .bank_wdata (bank_wdata)
   );

   always_comb begin
      io_rdata = RD_FLOAT;
      if (unlocked) begin
         if (hit_idx)                 io_rdata = idx;
         else if (hit_dat && in_bank) io_rdata = bank_rdata;
         else if (hit_dat && glb_hit) io_rdata = glb_rdata;
         else if (hit_dat)            io_rdata = RD_EMPTY;
      end
   end

   // R5: reads of either port return the float value while locked
   p_locked_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && io_rd && (hit_idx || hit_dat)) |-> io_rdata == RD_FLOAT);

   // R12: foreign addresses never move the port's index
   p_foreign_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !hit_idx) |=> $stable(idx));

endmodule

// File: tb/tb_cfg_keyed_port.sv
module tb_cfg_keyed_port;

   localparam logic [15:0] BASE  = 16'h004E;
   localparam logic [15:0] DATA  = 16'h004F;
   localparam logic [15:0] OTHER = 16'h002E;
   localparam logic [15:0] DEVID = 16'h0A52;
   localparam logic [7:0]  REV   = 8'h13;
   localparam logic [31:0] PRST  = 32'hD4_C3_B2_A1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata, bank_sel, bank_idx, bank_wdata, bank_rdata;
   logic        bank_we, bank_re;

   always #4 clk = ~clk;

   cfg_keyed_port #(
      .ADDR_W(16), .BASE_ADDR(BASE), .DEV_ID(DEVID), .DEV_REV(REV),
      .MFR_ID(16'h1934), .PINSEL_RST(PRST)
   ) dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .bank_sel(bank_sel),
      .bank_idx(bank_idx), .bank_we(bank_we), .bank_re(bank_re),
      .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
   );

   function automatic logic [7:0] dev_byte(input logic [7:0] sel, input logic [7:0] ix);
      return ix ^ {sel[3:0], sel[7:4]} ^ 8'h5A;
   endfunction
   assign bank_rdata = dev_byte(bank_sel, bank_idx);

   int unsigned we_cnt = 0;
   logic [7:0]  lg_sel, lg_idx, lg_dat;
   always @(posedge clk) begin
      if (bank_we) begin
         we_cnt <= we_cnt + 1;
         lg_sel <= bank_sel; lg_idx <= bank_idx; lg_dat <= bank_wdata;
      end
   end

   int unsigned n_tests = 0, n_fail = 0;
   bit done = 0;

   // bench model
   int         m_st;          // 0 locked, 1 armed, 2 open
   logic [7:0] m_idx, m_ldn;
   logic [7:0] m_pin [4];

   function automatic int pin_slot(input logic [7:0] ix);
      case (ix)
         8'h27: return 0;
         8'h29: return 1;
         8'h2A: return 2;
         8'h2B: return 3;
         default: return -1;
      endcase
   endfunction

   function automatic logic [7:0] exp_data();
      if (m_st != 2) return 8'hFF;
      if (m_idx >= 8'h30) return dev_byte(m_ldn, m_idx);
      if (pin_slot(m_idx) >= 0) return m_pin[pin_slot(m_idx)];
      case (m_idx)
         8'h07: return m_ldn;
         8'h20: return DEVID[15:8];
         8'h21: return DEVID[7:0];
         8'h22: return REV;
         8'h23: return 8'h19;
         8'h24: return 8'h34;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [15:0] a, output logic [7:0] d, output logic re);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      d = io_rdata; re = bank_re;
      io_rd = 1'b0;
   endtask

   task automatic idx_wr(input logic [7:0] v);
      bus_wr(BASE, v);
      case (m_st)
         0: m_st = (v == 8'h87) ? 1 : 0;
         1: m_st = (v == 8'h87) ? 2 : 0;
         default: if (v == 8'hAA) m_st = 0; else m_idx = v;
      endcase
   endtask

   task automatic dat_wr(input string req, input logic [7:0] v);
      int unsigned c0 = we_cnt;
      bus_wr(DATA, v);
      if (m_st == 2 && m_idx >= 8'h30) begin
         chk({req, " R10 bank_we count"}, we_cnt, c0 + 1);
         chk({req, " R10 bank log"}, {8'h0, lg_sel, lg_idx, lg_dat}, {8'h0, m_ldn, m_idx, v});
      end else begin
         chk({req, " R5/R11 no bank write"}, we_cnt, c0);
         if (m_st == 2) begin
            if (m_idx == 8'h07) m_ldn = v;
            if (pin_slot(m_idx) >= 0) m_pin[pin_slot(m_idx)] = v;
         end
      end
   endtask

   task automatic dat_chk(input string req);
      logic [7:0] d; logic re;
      bus_rd(DATA, d, re);
      chk({req, " data read"}, d, exp_data());
      chk({req, " R10 bank_re"}, re, (m_st == 2 && m_idx >= 8'h30));
   endtask

   task automatic idx_chk(input string req);
      logic [7:0] d; logic re;
      bus_rd(BASE, d, re);
      chk({req, " index read"}, d, (m_st == 2) ? m_idx : 8'hFF);
   endtask

   task automatic sel(input logic [7:0] ix, input logic [7:0] v);
      idx_wr(ix); dat_wr("R8 setup", v);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d; logic re;
      m_st = 0; m_idx = 8'h00; m_ldn = 8'h00;
      for (int i = 0; i < 4; i++) m_pin[i] = PRST[i*8 +: 8];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R5: locked after reset
      dat_chk("R1 R5 reset locked");
      idx_chk("R1 R5 reset index port");
      // R2: one key byte is not enough; data access between keys is allowed
      idx_wr(8'h87);
      dat_chk("R2 after one key");
      bus_rd(DATA, d, re);
      idx_wr(8'h87);
      idx_chk("R1 R2 open, index zero");
      dat_chk("R1 selector zero");
      // R4: lock byte keeps index
      idx_wr(8'h22);
      idx_wr(8'hAA);
      dat_chk("R4 locked after AA");
      // R3: stray byte between keys
      idx_wr(8'h87); idx_wr(8'h12); idx_wr(8'h87);
      dat_chk("R3 broken key stays locked");
      idx_wr(8'h87);
      idx_chk("R3 R4 open, index kept");
      // R7: ID bytes and read-only
      for (int k = 8'h20; k <= 8'h24; k++) begin
         idx_wr(8'(k)); dat_chk("R7 id byte");
         dat_wr("R7 write ignored", 8'h66); dat_chk("R7 id read-only");
      end
      // R8 / R10: selector drives banks
      sel(8'h07, 8'h05);
      dat_chk("R8 selector readback");
      idx_wr(8'h30); dat_wr("R8 R10 bank write", 8'hC7); dat_chk("R10 bank read");
      idx_wr(8'hFF); dat_wr("R10 top bank", 8'h01); dat_chk("R10 top bank read");
      chk("R8 bank_sel port", bank_sel, 8'h05);
      // R9: read-modify-write of one bit
      idx_wr(8'h29); dat_chk("R9 reset value");
      dat_wr("R9 rmw", m_pin[1] | 8'h40);
      for (int k = 0; k < 4; k++) begin
         idx_wr((k == 0) ? 8'h27 : (k == 1) ? 8'h29 : (k == 2) ? 8'h2A : 8'h2B);
         dat_chk("R9 pin regs");
      end
      // R11: empty global index
      idx_wr(8'h10); dat_wr("R11 empty write", 8'h99); dat_chk("R11 empty read");
      idx_wr(8'h2F); dat_chk("R11 below bank");
      // R12: foreign address
      bus_wr(OTHER, 8'hAA);
      bus_wr(OTHER + 16'd1, 8'h77);
      idx_chk("R12 foreign lock ignored");
      bus_rd(OTHER, d, re);
      chk("R12 foreign read", d, 8'hFF);
      // R5: locked writes have no effect
      idx_wr(8'h07); idx_wr(8'hAA);
      dat_wr("R5 locked write", 8'h3C);
      bus_wr(OTHER, 8'h87); bus_wr(OTHER, 8'h87);
      dat_chk("R5 R12 still locked");
      idx_wr(8'h87); idx_wr(8'h87);
      dat_chk("R5 selector unchanged");

      // random phase
      void'($urandom(32'd20240611));
      for (int n = 0; n < 600; n++) begin
         int unsigned op = $urandom % 8;
         int unsigned pk = $urandom % 12;
         logic [7:0] rb = 8'($urandom);
         logic [7:0] iv;
         case (pk)
            0, 1: iv = 8'h87;
            2:    iv = 8'hAA;
            3:    iv = 8'h07;
            4:    iv = 8'h20 + 8'($urandom % 5);
            5:    iv = (rb[0]) ? 8'h27 : 8'h2B;
            6:    iv = (rb[0]) ? 8'h29 : 8'h2A;
            7, 8: iv = 8'h30 | rb;
            default: iv = rb;
         endcase
         case (op)
            0, 1, 2: idx_wr(iv);
            3:       dat_wr("R10 random write", rb);
            4, 5:    dat_chk("R6 random data read");
            6:       idx_chk("R6 random index read");
            default: bus_wr(OTHER + 16'(rb[0]), iv);
         endcase
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule